// File: doc/BRIEF.md
# Chained Indexed-Indirect Effective Address Unit

This block works out the effective value E of a 36-bit instruction word. From the low 23 bits of the word it takes an 18-bit address, a 4-bit index register number and an indirect flag. When the index number is not zero, the right half of that index register is added to the address, modulo 2^18. When the indirect flag is set, the sum is used as a memory address. The word read there supplies a new flag, index number and address, and the same step runs again. The chain stops at the first word whose indirect flag is clear. The sum formed from that word is E.

The calculation runs for every instruction. It does not depend on how E is used later: as a memory address, a mask, a shift count or an immediate operand. A controller pulses `start_i` with the word on `instr_i` and waits for the one-cycle `done_o` pulse. Index registers are read through a combinational port. Indirect words come through a memory port that holds its request until the word is returned. An `abort_i` input lets a supervisor break off a chain that never ends.

Top module: `ea_chain_unit`

## Requirements
- R1: Field positions in a 36-bit word, where vector index 35 is the most significant bit. The indirect flag is `[22]`, the index register number is `[21:18]` and the address Y is `[17:0]`. Bits `[35:23]` (opcode and accumulator fields) have no effect on E.
- R2: An index number of 0 means no indexing, and the step value is Y. Register entry 0 never affects the result, whatever it holds.
- R3: An index number from 1 to 15 gives a step value of Y plus bits `[17:0]` of that register, modulo 2^18. The upper 18 bits of the register have no effect.
- R4: When the indirect flag is 1, the unit raises `mem_req_o` with `mem_addr_o` equal to the step value. It then repeats the step using the fields of the returned `mem_data_i`.
- R5: The chain ends at the first word whose indirect flag is 0. `ea_o` then takes that word's step value. Exactly one memory read is made per indirect word in the chain.
- R6: `done_o` is high for exactly one cycle per completed calculation, and `busy_o` is low while it is high. `ea_o` holds its value until the next completion.
- R7: A `start_i` pulse that arrives while `busy_o` is high is ignored. The calculation in progress finishes with its own result, and only one `done_o` pulse is produced.
- R8: `abort_i` returns the unit to idle on the next clock edge. `busy_o`, `mem_req_o` and `done_o` are then low, and no `done_o` pulse follows for the aborted calculation.
- R9: While `mem_req_o` is high and `mem_valid_i` is low, the request stays high and `mem_addr_o` stays stable.
- R10: After `start_i` is sampled in idle, `busy_o` rises on the next edge. For a word with the indirect flag clear, `done_o` is high after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a calculation on `instr_i` (taken only when idle) |
| abort_i | input | 1 | Return to idle at once, with no result |
| instr_i | input | 36 | Instruction word |
| rf_idx_o | output | 4 | Index register number being read |
| rf_data_i | input | 36 | Contents of the selected index register |
| mem_req_o | output | 1 | Indirect word read request, held until valid |
| mem_addr_o | output | 18 | Address of the indirect word |
| mem_valid_i | input | 1 | Indirect word is present on `mem_data_i` |
| mem_data_i | input | 36 | Returned indirect word |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse: `ea_o` is updated |
| ea_o | output | 18 | Effective value E |

## Verification
A direct word with all opcode and accumulator bits set and a non-zero entry 0 shows that only the low 23 bits matter. An indexed sum near the top of the 18-bit range shows that the addition wraps and that the index register's upper half is dropped. One-level and three-level indirect chains are run with different memory latencies, and the read addresses are logged. These runs separate a correct chain from one that stops too early, reads the wrong word or ignores indexing inside fetched words. A self-looping chain is broken with abort, and a start pulse is injected mid-chain, to show that neither corrupts the result.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EA_W   = 18;
  localparam int XR_W   = 4;
  localparam int WORD_W = 36;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CALC  = 2'd1,
    S_FETCH = 2'd2
  } ea_state_e;
endpackage

// File: rtl/ea_field_split.sv
module ea_field_split #(
  parameter int AW = ea_pkg::EA_W,
  parameter int XW = ea_pkg::XR_W,
  localparam int LW = AW + XW + 1
) (
  input  logic [LW-1:0] link_i,
  output logic          ind_o,
  output logic [XW-1:0] xsel_o,
  output logic [AW-1:0] yaddr_o
);
  localparam int X_LO   = AW;
  localparam int IND_AT = AW + XW;

  assign yaddr_o = link_i[AW-1:0];
  assign xsel_o  = link_i[IND_AT-1:X_LO];
  assign ind_o   = link_i[IND_AT];
endmodule

// File: rtl/ea_index_add.sv
module ea_index_add #(
  parameter int AW = ea_pkg::EA_W,
  parameter int XW = ea_pkg::XR_W
) (
  input  logic [XW-1:0] xsel_i,
  input  logic [AW-1:0] yaddr_i,
  input  logic [AW-1:0] xr_right_i,
  output logic          use_x_o,
  output logic [AW-1:0] step_o
);
  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    logic [AW:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[AW-1:0];
  endfunction

  assign use_x_o = (xsel_i != '0);
  assign step_o  = wrap_add(yaddr_i, use_x_o ? xr_right_i : '0);
endmodule

// File: rtl/ea_seq.sv
module ea_seq #(
  parameter int AW = ea_pkg::EA_W,
  parameter int XW = ea_pkg::XR_W,
  parameter int WW = ea_pkg::WORD_W,
  localparam int LW = AW + XW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [WW-1:0] instr_i,
  input  logic          mem_valid_i,
  input  logic [WW-1:0] mem_data_i,
  input  logic          link_ind_i,
  input  logic [AW-1:0] step_i,
  output logic [LW-1:0] link_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ea_o
);
  import ea_pkg::*;

  ea_state_e     state_q;
  logic [LW-1:0] link_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] ea_q;
  logic          done_q;

  logic unused_hi;
  assign unused_hi = ^{instr_i[WW-1:LW], mem_data_i[WW-1:LW]};

  // named events for the checks
  logic ev_accept, ev_hop, ev_finish, ev_land;
  assign ev_accept = (state_q == S_IDLE)  && start_i && !abort_i;
  assign ev_hop    = (state_q == S_CALC)  && link_ind_i && !abort_i;
  assign ev_finish = (state_q == S_CALC)  && !link_ind_i && !abort_i;
  assign ev_land   = (state_q == S_FETCH) && mem_valid_i && !abort_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      link_q  <= '0;
      addr_q  <= '0;
      ea_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE: if (start_i) begin
            link_q  <= instr_i[LW-1:0];
            state_q <= S_CALC;
          end
          S_CALC: if (link_ind_i) begin
            addr_q  <= step_i;
            state_q <= S_FETCH;
          end else begin
            ea_q    <= step_i;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
          S_FETCH: if (mem_valid_i) begin
            link_q  <= mem_data_i[LW-1:0];
            state_q <= S_CALC;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign link_o     = link_q;
  assign mem_req_o  = (state_q == S_FETCH);
  assign mem_addr_o = addr_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign ea_o       = ea_q;

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_finish_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (done_o && ea_o == $past(step_i)));
  p_hop_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hop |=> (mem_req_o && mem_addr_o == $past(step_i)));
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_valid_i && !abort_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !done_o && !mem_req_o));
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy_o);
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !ev_finish) |=> !done_o);
  p_land_calc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_land |=> (busy_o && !mem_req_o));
endmodule

// File: rtl/ea_chain_unit.sv
module ea_chain_unit #(
  parameter int AW = ea_pkg::EA_W,
  parameter int XW = ea_pkg::XR_W,
  parameter int WW = ea_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [WW-1:0] instr_i,
  output logic [XW-1:0] rf_idx_o,
  input  logic [WW-1:0] rf_data_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [WW-1:0] mem_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ea_o
);
  localparam int LW = AW + XW + 1;

  logic [LW-1:0] link;
  logic          link_ind;
  logic [XW-1:0] xsel;
  logic [AW-1:0] yaddr;
  logic [AW-1:0] step;
  logic          use_x;

  logic unused_rf;
  assign unused_rf = ^{rf_data_i[WW-1:AW], use_x};

  ea_field_split #(.AW(AW), .XW(XW)) u_split (
    .link_i (link),
    .ind_o  (link_ind),
    .xsel_o (xsel),
    .yaddr_o(yaddr)
  );

  ea_index_add #(.AW(AW), .XW(XW)) u_add (
    .xsel_i    (xsel),
    .yaddr_i   (yaddr),
    .xr_right_i(rf_data_i[AW-1:0]),
    .use_x_o   (use_x),
    .step_o    (step)
  );

  ea_seq #(.AW(AW), .XW(XW), .WW(WW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .instr_i    (instr_i),
    .mem_valid_i(mem_valid_i),
    .mem_data_i (mem_data_i),
    .link_ind_i (link_ind),
    .step_i     (step),
    .link_o     (link),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ea_o       (ea_o)
  );

  assign rf_idx_o = xsel;
endmodule

// File: tb/ea_chain_unit_tb.sv
`timescale 1ns/1ps
module ea_chain_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        abort_i = 1'b0;
  logic [35:0] instr_i = '0;
  logic [3:0]  rf_idx_o;
  logic [35:0] rf_data_i;
  logic        mem_req_o;
  logic [17:0] mem_addr_o;
  logic        mem_valid_i;
  logic [35:0] mem_data_i;
  logic        busy_o, done_o;
  logic [17:0] ea_o;

  always #2 clk = ~clk;

  ea_chain_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .instr_i(instr_i), .rf_idx_o(rf_idx_o), .rf_data_i(rf_data_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i),
    .busy_o(busy_o), .done_o(done_o), .ea_o(ea_o)
  );

  int vectors = 0;
  int misses  = 0;

  logic [35:0] rf [16];
  assign rf_data_i = rf[rf_idx_o];

  logic [17:0] tab_a [8];
  logic [35:0] tab_d [8];
  int          tab_n = 0;
  int          lat = 0;
  int          wait_cnt = 0;
  int          fetch_n = 0;
  logic [17:0] fetch_log [8];

  function automatic logic [35:0] lookup(input logic [17:0] a);
    for (int i = 0; i < tab_n; i++) if (tab_a[i] == a) return tab_d[i];
    return 36'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_valid_i <= 1'b0;
      mem_data_i  <= '0;
      wait_cnt    <= 0;
    end else if (mem_req_o && !mem_valid_i) begin
      if (wait_cnt >= lat) begin
        mem_valid_i <= 1'b1;
        mem_data_i  <= lookup(mem_addr_o);
        wait_cnt    <= 0;
        if (fetch_n < 8) fetch_log[fetch_n] <= mem_addr_o;
        fetch_n     <= fetch_n + 1;
      end else wait_cnt <= wait_cnt + 1;
    end else begin
      mem_valid_i <= 1'b0;
    end
  end

  function automatic logic [35:0] mk(input logic [8:0] op, input logic [3:0] ac,
                                     input logic ind, input logic [3:0] x,
                                     input logic [17:0] y);
    return {op, ac, ind, x, y};
  endfunction

  // independent model: fields pulled out by shifting and masking
  function automatic logic [17:0] model_ea(input logic [35:0] w0, output int hops);
    logic [35:0] w = w0;
    logic [18:0] s;
    int xi;
    hops = 0;
    for (int k = 0; k < 16; k++) begin
      xi = int'((w >> 18) & 36'hF);
      s  = 19'(w & 36'h3FFFF) + ((xi == 0) ? 19'd0 : 19'(rf[xi] & 36'h3FFFF));
      if (((w >> 22) & 36'h1) == 0) return s[17:0];
      hops++;
      w = lookup(s[17:0]);
    end
    return 18'h3FFFF;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [35:0] w, input int stray_at,
                     output int cyc, output int dones);
    cyc = 0; dones = 0;
    @(negedge clk);
    fetch_n = 0;
    instr_i = w; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      cyc++;
      start_i = (cyc == stray_at) ? 1'b1 : 1'b0;
      if (start_i) instr_i = mk(9'd0, 4'd0, 1'b0, 4'd0, 18'h00001);
      if (done_o) begin dones++; break; end
    end
    start_i = 1'b0;
    repeat (6) begin @(negedge clk); if (done_o) dones++; end
  endtask

  task automatic t_reset;
    check(!busy_o, "R6", "busy after reset", busy_o, 0);
    check(!done_o, "R6", "done after reset", done_o, 0);
    check(!mem_req_o, "R9", "req after reset", mem_req_o, 0);
  endtask

  task automatic t_direct;
    int c, d, h; logic [35:0] w; logic [17:0] e;
    rf[0] = '1;
    w = mk(9'h1FF, 4'hF, 1'b0, 4'd0, 18'h12345);
    e = model_ea(w, h);
    run(w, 0, c, d);
    check(ea_o == e, "R1", "opcode/ac ignored", ea_o, e);
    check(ea_o == 18'h12345, "R2", "index 0 unindexed", ea_o, 18'h12345);
    check(c == 1, "R10", "direct latency", c, 1);
    check(fetch_n == 0, "R5", "no fetch when direct", fetch_n, 0);
  endtask

  task automatic t_index;
    int c, d, h; logic [35:0] w; logic [17:0] e;
    rf[5] = {18'h2AAAA, 18'h00020};
    w = mk(9'd0, 4'd0, 1'b0, 4'd5, 18'h3FFF0);
    e = model_ea(w, h);
    run(w, 0, c, d);
    check(ea_o == e && e == 18'h00010, "R3", "wrapping index add", ea_o, e);
    rf[15] = {18'h3FFFF, 18'h00001};
    w = mk(9'h0AB, 4'h3, 1'b0, 4'd15, 18'h00100);
    e = model_ea(w, h);
    run(w, 0, c, d);
    check(ea_o == 18'h00101, "R3", "upper half dropped", ea_o, 18'h00101);
  endtask

  task automatic t_indirect;
    int c, d, h; logic [35:0] w; logic [17:0] e;
    rf[2] = {18'h11111, 18'h00010};
    rf[3] = {18'h22222, 18'h00005};
    tab_n = 1;
    tab_a[0] = 18'h01010; tab_d[0] = mk(9'h155, 4'hA, 1'b0, 4'd3, 18'h00200);
    lat = 0;
    w = mk(9'd0, 4'd0, 1'b1, 4'd2, 18'h01000);
    e = model_ea(w, h);
    run(w, 0, c, d);
    check(fetch_log[0] == 18'h01010, "R4", "indirect fetch address", fetch_log[0], 18'h01010);
    check(ea_o == e && e == 18'h00205, "R4", "indexed word after fetch", ea_o, e);
    check(fetch_n == 1, "R5", "one fetch", fetch_n, 1);
  endtask

  task automatic t_chain(input int latency, input int stray);
    int c, d, h; logic [35:0] w; logic [17:0] e;
    rf[4] = {18'h3FFFF, 18'h00100};
    tab_n = 3;
    tab_a[0] = 18'h02000; tab_d[0] = mk(9'd0, 4'd0, 1'b1, 4'd0, 18'h03000);
    tab_a[1] = 18'h03000; tab_d[1] = mk(9'd0, 4'd0, 1'b1, 4'd4, 18'h00010);
    tab_a[2] = 18'h00110; tab_d[2] = mk(9'h1FF, 4'hF, 1'b0, 4'd0, 18'h00777);
    lat = latency;
    w = mk(9'd0, 4'd0, 1'b1, 4'd0, 18'h02000);
    e = model_ea(w, h);
    run(w, stray, c, d);
    if (stray == 0) begin
      check(ea_o == e && e == 18'h00777, "R5", "three-level chain", ea_o, e);
      check(fetch_n == h, "R5", "fetch count", fetch_n, h);
      check(fetch_log[2] == 18'h00110, "R9", "third address held", fetch_log[2], 18'h00110);
    end else begin
      check(ea_o == e, "R7", "stray start ignored", ea_o, e);
      check(d == 1, "R7", "single done", d, 1);
    end
  endtask

  task automatic t_done_pulse;
    logic [17:0] held;
    held = ea_o;
    @(negedge clk);
    check(!done_o, "R6", "done low after pulse", done_o, 0);
    check(ea_o == held, "R6", "ea holds", ea_o, held);
  endtask

  task automatic t_abort;
    int d;
    tab_n = 1;
    tab_a[0] = 18'h04000; tab_d[0] = mk(9'd0, 4'd0, 1'b1, 4'd0, 18'h04000);
    lat = 1; d = 0;
    @(negedge clk);
    instr_i = mk(9'd0, 4'd0, 1'b1, 4'd0, 18'h04000); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (20) begin @(negedge clk); if (done_o) d++; end
    check(busy_o, "R8", "loop still busy", busy_o, 1);
    abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    check(!busy_o && !mem_req_o, "R8", "idle after abort", {busy_o, mem_req_o}, 0);
    repeat (5) begin @(negedge clk); if (done_o) d++; end
    check(d == 0, "R8", "no done from aborted run", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 36'(i * 36'h1001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_index();
    t_indirect();
    t_chain(2, 0);
    t_done_pulse();
    t_chain(3, 4);
    t_abort();
    t_direct();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule